// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block turns every data-memory access of a small processor core into a physical register-file address. It also works out which storage sits behind that address. The register file is split into four banks of 128 locations. A direct access picks its bank with two bank bits held in the status word and takes the location within the bank from the 7-bit offset in the instruction. An indirect access ignores the instruction offset. It builds the address from the file-select pointer, with one more status bit on top.

Each access is classified into one of four regions. The bottom 32 offsets of a bank are control-register space. Everything above them is general purpose RAM. A small set of control registers is visible at the same offset in every bank, and all of those copies fold onto one physical register in bank 0. The upper half of the control-register space in banks 2 and 3 is not built. The decoder registers the address and the region, steers read and write strobes to either the RAM port or the control-register port, and returns the read data of the selected port. For an unbuilt location it returns zero.

Top module: `bank_rf_decoder`

## Requirements
- R1: A direct access (indirect_i = 0) forms the 9-bit address {status_i[6:5], offset_i}. Bits 7 and 4:0 of status_i have no effect.
- R2: An indirect access (indirect_i = 1) forms the 9-bit address {status_i[7], fsr_i}. offset_i and status_i[6:0] have no effect.
- R3: Offsets 00h–1Fh of banks 0 and 1, and offsets 00h–0Fh of banks 2 and 3, are control-register space: region_o = 0 and addr_o is the formed address. Strobes go to the control-register port.
- R4: Offsets 20h–7Fh of every bank are RAM: region_o = 1 and addr_o is the formed address. Strobes go to the RAM port.
- R5: Offsets 03h, 04h and 0Bh in any bank are mirrored: region_o = 2 and addr_o = {2'b00, offset}, so every bank folds onto bank 0. Strobes go to the control-register port.
- R6: Offsets 10h–1Fh of banks 2 and 3 are unimplemented: region_o = 3, addr_o is the formed address, no strobe is raised and rdata_o is 0. A write there is ignored.
- R7: After reset addr_o = 0, region_o = 3 and all strobes are 0. Outputs reflect the request sampled at the previous rising clock edge.
- R8: rdata_o equals sfr_rdata_i for regions 0 and 2, ram_rdata_i for region 1 and 0 for region 3, combinationally from the registered region.
- R9: rd_i and wr_i may be high together. Both strobes of the selected port then rise in the same cycle, and the other port stays quiet.
- R10: A read strobe rises only for a sampled rd_i, and a write strobe only for a sampled wr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 8 | Status word carrying the bank bits (6:5) and the indirect bank bit (7) |
| offset_i | input | 7 | Instruction location offset |
| indirect_i | input | 1 | Selects addressing through the file-select pointer |
| fsr_i | input | 8 | File-select pointer |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| ram_rdata_i | input | 8 | Read data from the RAM port |
| sfr_rdata_i | input | 8 | Read data from the control-register port |
| addr_o | output | 9 | Registered physical address |
| region_o | output | 2 | Registered region: 0 control, 1 RAM, 2 mirror, 3 unimplemented |
| ram_re_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| sfr_re_o | output | 1 | Control-register read strobe |
| sfr_we_o | output | 1 | Control-register write strobe |
| rdata_o | output | 8 | Returned read data |

## Verification
A read and a write can land on the same location in one cycle, as a read-modify-write does. The bench rotates the request pattern through none, read, write and both while it sweeps every direct bank and offset and every indirect pointer value. When both requests are high it expects both strobes of the port that the arithmetic model picks and nothing on the other port. When the location is unbuilt it expects no strobe at all.

// File: rtl/rfdec_pkg.sv
package rfdec_pkg;
  typedef enum logic [1:0] {
    REG_SFR  = 2'd0,
    REG_GPR  = 2'd1,
    REG_MIR  = 2'd2,
    REG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/bank_addr_mux.sv
module bank_addr_mux #(
  parameter int BANK_W = 2,
  parameter int OFS_W  = 7,
  parameter int DATA_W = 8,
  parameter int RP_LO  = 5,
  parameter int IRP    = 7,
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  logic [DATA_W-1:0] status_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic              indirect_i,
  input  logic [DATA_W-1:0] fsr_i,
  output logic [ADDR_W-1:0] raw_addr_o
);
  logic [ADDR_W-1:0] direct_addr;
  logic [ADDR_W-1:0] indir_addr;

  assign direct_addr = {status_i[RP_LO+BANK_W-1:RP_LO], offset_i};
  assign indir_addr  = {status_i[IRP], fsr_i};
  assign raw_addr_o  = indirect_i ? indir_addr : direct_addr;

  logic unused_status;
  assign unused_status = ^status_i[RP_LO-1:0];
endmodule

// File: rtl/region_decode.sv
module region_decode
  import rfdec_pkg::*;
#(
  parameter int BANK_W         = 2,
  parameter int OFS_W          = 7,
  parameter int SFR_SPAN       = 32,
  parameter int FULL_SFR_BANKS = 2,
  parameter int MIR_N          = 3,
  parameter logic [MIR_N*OFS_W-1:0] MIR_LIST = {7'h0B, 7'h04, 7'h03},
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  logic [ADDR_W-1:0] raw_addr_i,
  output logic [ADDR_W-1:0] phys_addr_o,
  output region_e           region_o
);
  localparam int HALF_SPAN = SFR_SPAN / 2;

  logic [OFS_W-1:0]  ofs;
  logic [BANK_W-1:0] bank;
  logic [MIR_N-1:0]  mir_hit;

  assign ofs  = raw_addr_i[OFS_W-1:0];
  assign bank = raw_addr_i[ADDR_W-1:OFS_W];

  for (genvar g = 0; g < MIR_N; g++) begin : g_mir
    assign mir_hit[g] = (ofs == MIR_LIST[g*OFS_W +: OFS_W]);
  end

  always_comb begin
    phys_addr_o = raw_addr_i;
    region_o    = REG_GPR;
    if (|mir_hit) begin
      region_o    = REG_MIR;
      phys_addr_o = {{BANK_W{1'b0}}, ofs};
    end else if (int'(ofs) < SFR_SPAN) begin
      if (int'(bank) >= FULL_SFR_BANKS && int'(ofs) >= HALF_SPAN)
        region_o = REG_NONE;
      else
        region_o = REG_SFR;
    end
  end
endmodule

// File: rtl/access_ctrl.sv
module access_ctrl
  import rfdec_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 8,
  parameter int OFS_W    = 7,
  parameter int SFR_SPAN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] phys_addr_i,
  input  region_e           region_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] sfr_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output region_e           region_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic              sfr_re_o,
  output logic              sfr_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  region_e           region_q;
  logic              re_q, we_q;
  logic              to_ram, to_sfr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      region_q <= REG_NONE;
      re_q     <= 1'b0;
      we_q     <= 1'b0;
    end else begin
      addr_q   <= phys_addr_i;
      region_q <= region_i;
      re_q     <= rd_i;
      we_q     <= wr_i;
    end
  end

  assign to_ram   = (region_q == REG_GPR);
  assign to_sfr   = (region_q == REG_SFR) || (region_q == REG_MIR);
  assign ram_re_o = re_q && to_ram;
  assign ram_we_o = we_q && to_ram;
  assign sfr_re_o = re_q && to_sfr;
  assign sfr_we_o = we_q && to_sfr;
  assign addr_o   = addr_q;
  assign region_o = region_q;

  always_comb begin
    unique case (region_q)
      REG_GPR:          rdata_o = ram_rdata_i;
      REG_SFR, REG_MIR: rdata_o = sfr_rdata_i;
      default:          rdata_o = '0;
    endcase
  end

  p_port_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((ram_re_o || ram_we_o) && (sfr_re_o || sfr_we_o)));

  p_unimpl_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == REG_NONE) |-> !(ram_re_o || ram_we_o || sfr_re_o || sfr_we_o));

  p_rd_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re_o || sfr_re_o) |-> $past(rd_i));

  p_wr_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o || sfr_we_o) |-> $past(wr_i));

  p_addr_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o == $past(phys_addr_i));

  p_gpr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == REG_GPR) |-> (int'(addr_o[OFS_W-1:0]) >= SFR_SPAN));
endmodule

// File: rtl/bank_rf_decoder.sv
module bank_rf_decoder
  import rfdec_pkg::*;
#(
  parameter int BANK_W         = 2,
  parameter int OFS_W          = 7,
  parameter int DATA_W         = 8,
  parameter int SFR_SPAN       = 32,
  parameter int FULL_SFR_BANKS = 2,
  parameter int MIR_N          = 3,
  parameter logic [MIR_N*OFS_W-1:0] MIR_LIST = {7'h0B, 7'h04, 7'h03},
  localparam int ADDR_W = BANK_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] status_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic              indirect_i,
  input  logic [DATA_W-1:0] fsr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] sfr_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        region_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic              sfr_re_o,
  output logic              sfr_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] raw_addr;
  logic [ADDR_W-1:0] phys_addr;
  region_e           region_d;
  region_e           region_q;

  bank_addr_mux #(
    .BANK_W(BANK_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .RP_LO(5), .IRP(7)
  ) u_mux (
    .status_i   (status_i),
    .offset_i   (offset_i),
    .indirect_i (indirect_i),
    .fsr_i      (fsr_i),
    .raw_addr_o (raw_addr)
  );

  region_decode #(
    .BANK_W(BANK_W), .OFS_W(OFS_W), .SFR_SPAN(SFR_SPAN),
    .FULL_SFR_BANKS(FULL_SFR_BANKS), .MIR_N(MIR_N), .MIR_LIST(MIR_LIST)
  ) u_dec (
    .raw_addr_i  (raw_addr),
    .phys_addr_o (phys_addr),
    .region_o    (region_d)
  );

  access_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .SFR_SPAN(SFR_SPAN)
  ) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phys_addr_i (phys_addr),
    .region_i    (region_d),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .ram_rdata_i (ram_rdata_i),
    .sfr_rdata_i (sfr_rdata_i),
    .addr_o      (addr_o),
    .region_o    (region_q),
    .ram_re_o    (ram_re_o),
    .ram_we_o    (ram_we_o),
    .sfr_re_o    (sfr_re_o),
    .sfr_we_o    (sfr_we_o),
    .rdata_o     (rdata_o)
  );

  assign region_o = region_q;

  p_mirror_fold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == 2'd2) |-> (addr_o[ADDR_W-1:OFS_W] == '0));

  p_unimpl_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == 2'd3) |-> (rdata_o == '0));
endmodule

// File: tb/bank_rf_decoder_bench.sv
`timescale 1ns/1ps
module bank_rf_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] status_i = '0;
  logic [6:0] offset_i = '0;
  logic       indirect_i = 1'b0;
  logic [7:0] fsr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] ram_rdata_i = 8'hC3;
  logic [7:0] sfr_rdata_i = 8'h3C;
  logic [8:0] addr_o;
  logic [1:0] region_o;
  logic       ram_re_o, ram_we_o, sfr_re_o, sfr_we_o;
  logic [7:0] rdata_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_rf_decoder u_bank_rf_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .status_i(status_i), .offset_i(offset_i),
    .indirect_i(indirect_i), .fsr_i(fsr_i), .rd_i(rd_i), .wr_i(wr_i),
    .ram_rdata_i(ram_rdata_i), .sfr_rdata_i(sfr_rdata_i), .addr_o(addr_o),
    .region_o(region_o), .ram_re_o(ram_re_o), .ram_we_o(ram_we_o),
    .sfr_re_o(sfr_re_o), .sfr_we_o(sfr_we_o), .rdata_o(rdata_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input bit ind, input logic [7:0] st, input logic [6:0] ofs,
                          input logic [7:0] fs, input bit rb, input bit wb);
    logic [8:0] raw, exp_addr;
    int o, b, exp_reg;
    bit ram_sel, sfr_sel;
    int exp_rd;
    @(negedge clk);
    indirect_i = ind; status_i = st; offset_i = ofs; fsr_i = fs; rd_i = rb; wr_i = wb;
    raw = ind ? {st[7], fs} : {st[6:5], ofs};
    o = int'(raw[6:0]);
    b = int'(raw[8:7]);
    exp_addr = raw;
    if (o == 3 || o == 4 || o == 11) begin
      exp_reg = 2; exp_addr = {2'b00, raw[6:0]};
    end else if (o < 32) begin
      exp_reg = (b >= 2 && o >= 16) ? 3 : 0;
    end else begin
      exp_reg = 1;
    end
    ram_sel = (exp_reg == 1);
    sfr_sel = (exp_reg == 0 || exp_reg == 2);
    exp_rd  = ram_sel ? 'hC3 : (sfr_sel ? 'h3C : 0);
    @(negedge clk);
    chk(ind ? "R2 addr" : "R1 addr", int'(addr_o), int'(exp_addr));
    case (exp_reg)
      0: chk("R3 region", int'(region_o), 0);
      1: chk("R4 region", int'(region_o), 1);
      2: chk("R5 region", int'(region_o), 2);
      default: chk("R6 region", int'(region_o), 3);
    endcase
    chk("R9 strobes", int'({ram_re_o, ram_we_o, sfr_re_o, sfr_we_o}),
        int'({ram_sel & rb, ram_sel & wb, sfr_sel & rb, sfr_sel & wb}));
    if (!rb && !wb) chk("R10 idle", int'(ram_re_o | ram_we_o | sfr_re_o | sfr_we_o), 0);
    chk("R8 rdata", int'(rdata_o), exp_rd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset addr", int'(addr_o), 0);
    chk("R7 reset region", int'(region_o), 3);
    chk("R7 reset strobes", int'({ram_re_o, ram_we_o, sfr_re_o, sfr_we_o}), 0);
    chk("R6 reset rdata", int'(rdata_o), 0);
    rst_ni = 1'b1;
    for (int bk = 0; bk < 4; bk++) begin
      for (int of = 0; of < 128; of++) begin
        logic [7:0] st;
        st = {of[0], bk[1:0], of[4:0] ^ 5'h15};
        run_case(1'b0, st, of[6:0], 8'(of * 3), of[0], of[1]);
      end
    end
    for (int hi = 0; hi < 2; hi++) begin
      for (int fv = 0; fv < 256; fv++) begin
        logic [7:0] st;
        st = {hi[0], fv[1:0], fv[6:2]};
        run_case(1'b1, st, ~fv[6:0], fv[7:0], fv[2], fv[3]);
      end
    end
    // R6: write to an unimplemented location raises nothing
    run_case(1'b0, 8'h40, 7'h18, 8'h00, 1'b0, 1'b1);
    chk("R6 write ignored", int'({ram_we_o, sfr_we_o}), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule